// File: doc/BRIEF.md
# Serial Gray-Code to Binary Decoder

This block turns a continuous serial stream of 4-bit reflected Gray-code words into the matching stream of binary bits. One Gray bit enters per clock, most significant bit first, and the binary bit for that position leaves in the same cycle. Words follow each other with no idle cycle, so the bit after a word's least significant bit is the most significant bit of the next word.

The block is a Mealy machine. Its state is a bit-position counter and the binary bit produced in the previous cycle. At the first position of a word the output copies the input. At every later position the output is the input XOR the previous output. A marker output goes high on the first bit of each word, so the surrounding logic can frame the stream. An asynchronous active-low reset returns the machine to the start of a word.

Top module: `gray_serial_decoder`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `word_start_o` is 1 and the bit on `gray_i` is treated as the most significant bit of a new word; this also holds when reset is applied in the middle of a word.
- R2: In a cycle where `word_start_o` is 1, `bin_o` equals `gray_i`.
- R3: In a cycle where `word_start_o` is 0, `bin_o` equals `gray_i` XOR the value `bin_o` had in the previous cycle.
- R4: `word_start_o` is 1 in exactly one cycle out of every 4, and it rises again in the cycle right after the fourth bit of a word.
- R5: The output has no clock latency: a change on `gray_i` inside a cycle changes `bin_o` in that same cycle.
- R6: Words run back to back: the bits of one word have no effect on the output bits of the next word.
- R7: The four output bits of a word, read most significant first, are the binary value of the reflected Gray input word; for example Gray 0011 gives 0010, 0110 gives 0100, 1000 gives 1111 and 1010 gives 1100, and all 16 codes map correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset to the start-of-word state |
| gray_i | input | 1 | Serial Gray-code bit, most significant bit of each word first |
| bin_o | output | 1 | Serial binary bit for the current input bit, same cycle |
| word_start_o | output | 1 | High while the current bit is the first bit of a word |

## Verification
A wrong position count shows at once on `word_start_o`, which the bench compares against its own model on every cycle, and it also makes the chain restart at the wrong bit, so the reassembled word is wrong within four cycles. A wrong stored previous bit shows on `bin_o` in the very next non-first cycle of a word. A previous bit that leaks across a word boundary shows on the first bit of the next word, which the bench exposes by sending all sixteen codes in shuffled order back to back.

// File: rtl/gsd_pkg.sv
package gsd_pkg;
  // Word length of the serial stream
  parameter int unsigned WORD_BITS_DEF = 4;

  function automatic int unsigned pos_width(input int unsigned bits);
    return (bits > 1) ? $clog2(bits) : 1;
  endfunction
endpackage

// File: rtl/gsd_pos_counter.sv
module gsd_pos_counter
  import gsd_pkg::*;
#(
  parameter int unsigned WORD_BITS = WORD_BITS_DEF
) (
  input  logic clk,
  input  logic rst_n,
  output logic first_o
);
  localparam int unsigned POS_W = pos_width(WORD_BITS);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(WORD_BITS - 1);

  logic [POS_W-1:0] pos_q;
  logic [POS_W-1:0] pos_d;

  generate
    if ((1 << POS_W) == WORD_BITS) begin : g_pow2
      // Natural wrap of the counter closes the word
      always_comb pos_d = pos_q + 1'b1;
    end else begin : g_cmp
      always_comb pos_d = (pos_q == LAST_POS) ? '0 : pos_q + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= '0;
    else        pos_q <= pos_d;
  end

  assign first_o = (pos_q == '0);
endmodule

// File: rtl/gsd_xor_chain.sv
module gsd_xor_chain (
  input  logic clk,
  input  logic rst_n,
  input  logic first_i,
  input  logic gray_i,
  output logic bin_o
);
  logic prev_q;
  logic carry;

  // The stored bit is masked at a word's first position
  always_comb begin
    carry = prev_q & ~first_i;
    bin_o = gray_i ^ carry;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= bin_o;
  end
endmodule

// File: rtl/gray_serial_decoder.sv
module gray_serial_decoder
  import gsd_pkg::*;
#(
  parameter int unsigned WORD_BITS = WORD_BITS_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic gray_i,
  output logic bin_o,
  output logic word_start_o
);
  logic first;

  gsd_pos_counter #(.WORD_BITS(WORD_BITS)) u_pos (
    .clk     (clk),
    .rst_n   (rst_n),
    .first_o (first)
  );

  gsd_xor_chain u_chain (
    .clk     (clk),
    .rst_n   (rst_n),
    .first_i (first),
    .gray_i  (gray_i),
    .bin_o   (bin_o)
  );

  assign word_start_o = first;
endmodule

// File: rtl/gsd_checker.sv
module gsd_checker #(
  parameter int unsigned WORD_BITS = 4
) (
  input logic clk,
  input logic rst_n,
  input logic gray_i,
  input logic bin_o,
  input logic word_start_o
);
  localparam int unsigned CW = $clog2(WORD_BITS) + 1;
  localparam logic [CW-1:0] LAST_CNT = CW'(WORD_BITS - 1);

  logic [CW-1:0] since_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            since_start <= '0;
    else if (word_start_o) since_start <= CW'(1);
    else                   since_start <= since_start + 1'b1;
  end

  // R1: reset holds the machine at a word start
  always @(negedge clk)
    if (!rst_n) a_r1_reset_start: assert (word_start_o);

  // R2: first bit copies the Gray bit
  a_r2_msb_copy: assert property (@(posedge clk) disable iff (!rst_n)
    word_start_o |-> (bin_o == gray_i));

  // R3: later bits chain through the previous output
  a_r3_xor_chain: assert property (@(posedge clk) disable iff (!rst_n)
    !word_start_o |-> (bin_o == (gray_i ^ $past(bin_o))));

  // R4: start marker is a single cycle
  a_r4_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    word_start_o |=> !word_start_o);

  // R4: start marker returns right after the last bit
  a_r4_start_period: assert property (@(posedge clk) disable iff (!rst_n)
    (!word_start_o && since_start == LAST_CNT) |=> word_start_o);
endmodule

bind gray_serial_decoder gsd_checker #(.WORD_BITS(WORD_BITS)) u_gsd_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .gray_i       (gray_i),
  .bin_o        (bin_o),
  .word_start_o (word_start_o)
);

// File: tb/tb_gray_serial_decoder.sv
module tb_gray_serial_decoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic gray_i = 1'b0;
  logic bin_o;
  logic word_start_o;

  int errors = 0;
  int checks = 0;
  int ref_pos = 0;
  bit ref_prev = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gray_serial_decoder dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .gray_i       (gray_i),
    .bin_o        (bin_o),
    .word_start_o (word_start_o)
  );

  function automatic logic [3:0] gray_to_bin(input logic [3:0] g);
    logic [3:0] b;
    b[3] = g[3];
    for (int k = 2; k >= 0; k--) b[k] = b[k+1] ^ g[k];
    return b;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Drive one bit, compare against the cycle model, return output bit
  task automatic send_bit(input bit g, output bit b);
    bit exp_start;
    bit exp_bin;
    @(negedge clk);
    gray_i = g;
    #1;
    exp_start = (ref_pos == 0);
    exp_bin   = exp_start ? g : (g ^ ref_prev);
    chk(word_start_o == exp_start, "R4", "word_start_o", word_start_o, exp_start);
    chk(bin_o == exp_bin, exp_start ? "R2" : "R3", "bin_o", bin_o, exp_bin);
    b = bin_o;
    ref_prev = exp_bin;
    ref_pos = (ref_pos + 1) % 4;
  endtask

  task automatic send_word(input logic [3:0] w, input string req);
    logic [3:0] got;
    bit b;
    for (int i = 3; i >= 0; i--) begin
      send_bit(w[i], b);
      got[i] = b;
    end
    chk(got == gray_to_bin(w), req, $sformatf("word for gray %b", w),
        got, gray_to_bin(w));
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int order[16];
    bit b;
    repeat (3) @(negedge clk);
    chk(word_start_o == 1'b1, "R1", "word_start_o in reset", word_start_o, 1);
    @(posedge clk);
    #1 rst_n = 1'b1;
    ref_pos = 0;

    // R7: listed examples
    send_word(4'b0011, "R7");
    send_word(4'b0110, "R7");
    send_word(4'b1000, "R7");
    send_word(4'b1010, "R7");

    // R6/R7: all 16 codes shuffled, back to back
    for (int i = 0; i < 16; i++) order[i] = i;
    for (int i = 15; i > 0; i--) begin
      int j;
      int t;
      j = $urandom_range(i, 0);
      t = order[i]; order[i] = order[j]; order[j] = t;
    end
    for (int i = 0; i < 16; i++) send_word(4'(order[i]), "R6");

    // R6: a word ending with output 1 followed by a word starting at 0
    send_word(4'b1000, "R6");
    send_word(4'b0000, "R6");

    // R5: same-cycle response to an input change at a later position
    send_bit(1'b1, b);
    @(negedge clk);
    gray_i = 1'b0;
    #1;
    begin
      bit first_val;
      first_val = bin_o;
      gray_i = 1'b1;
      #1;
      chk(bin_o == ~first_val, "R5", "bin_o after gray_i toggle", bin_o, ~first_val);
      ref_prev = bin_o;
      ref_pos = (ref_pos + 1) % 4;
    end

    // R1: reset in the middle of a word restarts framing
    rst_n = 1'b0;
    #1;
    chk(word_start_o == 1'b1, "R1", "word_start_o after mid-word reset", word_start_o, 1);
    @(posedge clk);
    #1 rst_n = 1'b1;
    ref_pos = 0;
    ref_prev = 1'b0;
    send_word(4'b1011, "R1");
    send_word(4'b1101, "R7");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule